// File: doc/BRIEF.md
# Center-Aligned Up/Down Timer with Buffered Reload

This block is a general-purpose timer whose counter sweeps up and down in center-aligned fashion. A prescaler divides the clock first. The counter advances once per prescaler tick. It rises from 0 until it reaches the active reload value minus one, then turns at the top and falls back to 0, and repeats. The turn at the top is an overflow and the turn at the bottom is an underflow. Either one may cause an update event.

The prescaler divisor and the reload value are written into buffer registers. They move into the active copies only on an update event. Software can request an update. It can also block updates from overflow and underflow while it rewrites the buffers. A separate control bit lets a software update happen without raising the update flag.

Software reaches the block through a simple register port. A write takes effect on the clock edge at which `wr_en` is high. A read returns the addressed register in the same cycle. The port has no handshake or back-pressure, because every write is accepted in its cycle. Three plain status pins leave the block: the counting direction, a one-cycle update pulse and an interrupt request.

Top module: `ctm_top`

## Requirements
- R1: After reset the counter, the prescaler count, the direction (0 = up), the update flag, the update pulse, the interrupt and the control register are all 0.
- R2: With active reload A > 0, the counter counts up 0, 1, ..., A-1. On the next tick (overflow) it loads A and sets direction to 1. It then counts down to 1. On the next tick (underflow) it loads 0 and sets direction to 0. The direction pin and control bit 4 show this direction.
- R3: The counter advances only on prescaler ticks. With active prescaler value P, a tick comes once every P+1 enabled clocks.
- R4: Register 2 (prescaler) and register 3 (reload) hold buffer values. The active copies load from them only on an update event. On an overflow update, the counter loads the new reload value as its turning point.
- R5: Writing 1 to bit 0 of register 1 requests an update. The counter and the prescaler count restart at 0, the direction goes up, and (unless R6 blocks it) the active copies load from the buffers.
- R6: While control bit 1 (update disable) is 1, no update event occurs. There is no load, no flag and no pulse. The counter keeps sweeping with the active reload value.
- R7: While control bit 2 (quiet software update) is 1, a software update does not set the flag. Overflow and underflow updates still set it.
- R8: The update flag is bit 0 of register 4. It is set by each update event not covered by R7, and it is cleared by writing 1 to that bit. Writing 0 has no effect. The `irq` output is the flag gated by control bit 3 (interrupt enable).
- R9: Control bit 0 (run) gates counting. Clearing it freezes the counter and the prescaler count without resetting them.
- R10: Control bit 4 is read-only. Writes to it do not change the direction.
- R11: With active reload 0, the counter holds its value and makes no overflow or underflow.
- R12: `upd_pulse` is high for exactly the one cycle after the clock edge at which an update event takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address (0 ctrl, 1 update request, 2 prescaler, 3 reload, 4 flag) |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 3 | Read address (5 returns the counter) |
| rd_data | output | DATA_W | Read data, combinational |
| dir_o | output | 1 | Counting direction, 1 = down |
| upd_pulse | output | 1 | One-cycle update event pulse |
| irq | output | 1 | Update interrupt request |

## Verification
Several properties are checked by assertions on every cycle:
- the counter never exceeds the active reload value;
- the counter does not move while it is stopped;
- update disable keeps both the pulse and the active reload still;
- a quiet software update leaves a clear flag clear;
- direction rises only at the reload value.

Other behaviour can only be shown by the bench scenarios: the exact sweep position after a given number of prescaled ticks, the new reload taking effect at an overflow, and the flag's write-one-to-clear behaviour.

// File: rtl/ctm_pkg.sv
package ctm_pkg;
  typedef enum logic [2:0] {
    A_CTRL = 3'd0,
    A_GEN  = 3'd1,
    A_PSC  = 3'd2,
    A_ARR  = 3'd3,
    A_FLAG = 3'd4,
    A_CNT  = 3'd5
  } reg_addr_e;

  localparam int ADDR_W = 3;

  // control register layout, bit 0 at the bottom
  typedef struct packed {
    logic irq_en;    // bit 3
    logic quiet_sw;  // bit 2
    logic upd_off;   // bit 1
    logic run;       // bit 0
  } ctrl_t;
endpackage

// File: rtl/ctm_regs.sv
module ctm_regs
  import ctm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              dir,
  input  logic              flag_set,
  output ctrl_t             ctrl,
  output logic [PSC_W-1:0]  psc_buf,
  output logic [CNT_W-1:0]  arr_buf,
  output logic              sw_req,
  output logic              flag
);
  localparam int CTRL_W = $bits(ctrl_t);

  logic wr_ctrl, wr_psc, wr_arr, wr_flag;

  assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
  assign wr_psc  = wr_en && (wr_addr == A_PSC);
  assign wr_arr  = wr_en && (wr_addr == A_ARR);
  assign wr_flag = wr_en && (wr_addr == A_FLAG);
  assign sw_req  = wr_en && (wr_addr == A_GEN) && wr_data[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl    <= '0;
      psc_buf <= '0;
      arr_buf <= '0;
      flag    <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl    <= ctrl_t'(wr_data[CTRL_W-1:0]);
      if (wr_psc)  psc_buf <= wr_data[PSC_W-1:0];
      if (wr_arr)  arr_buf <= wr_data[CNT_W-1:0];
      // a new event wins over a clear in the same cycle
      if (flag_set)                 flag <= 1'b1;
      else if (wr_flag && wr_data[0]) flag <= 1'b0;
    end
  end

  always_comb begin
    case (rd_addr)
      A_CTRL:  rd_data = DATA_W'({dir, ctrl});
      A_PSC:   rd_data = DATA_W'(psc_buf);
      A_ARR:   rd_data = DATA_W'(arr_buf);
      A_FLAG:  rd_data = DATA_W'(flag);
      A_CNT:   rd_data = DATA_W'(cnt);
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/ctm_prescaler.sv
module ctm_prescaler #(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic             load,
  input  logic [PSC_W-1:0] psc_new,
  output logic             tick
);
  logic [PSC_W-1:0] pcnt;
  logic [PSC_W-1:0] psc_act;

  assign tick = run && (pcnt >= psc_act);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcnt    <= '0;
      psc_act <= '0;
    end else begin
      if (load) psc_act <= psc_new;
      if (restart)   pcnt <= '0;
      else if (tick) pcnt <= '0;
      else if (run)  pcnt <= pcnt + 1'b1;
    end
  end
endmodule

// File: rtl/ctm_counter.sv
module ctm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  logic             load,
  input  logic [CNT_W-1:0] arr_new,
  output logic [CNT_W-1:0] cnt,
  output logic             dir,
  output logic [CNT_W-1:0] arr_act,
  output logic             ovf,
  output logic             udf
);
  logic live;

  assign live = tick && (arr_act != '0);
  assign ovf  = live && !dir && (cnt >= arr_act - CNT_W'(1));
  assign udf  = live && dir && (cnt <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      dir     <= 1'b0;
      arr_act <= '0;
    end else begin
      if (load) arr_act <= arr_new;
      if (restart) begin
        cnt <= '0;
        dir <= 1'b0;
      end else if (ovf) begin
        // turning point follows a reload taken at this same edge
        cnt <= load ? arr_new : arr_act;
        dir <= 1'b1;
      end else if (udf) begin
        cnt <= '0;
        dir <= 1'b0;
      end else if (live) begin
        cnt <= dir ? cnt - 1'b1 : cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ctm_top.sv
module ctm_top
  import ctm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 16,
  parameter int DATA_W = (CNT_W > PSC_W) ? CNT_W : PSC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [2:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              dir_o,
  output logic              upd_pulse,
  output logic              irq
);
  ctrl_t            ctrl;
  logic [PSC_W-1:0] psc_buf;
  logic [CNT_W-1:0] arr_buf;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] arr_act;
  logic             dir_q, sw_req, flag_q, flag_set;
  logic             tick, ovf, udf, ue;

  assign ue       = !ctrl.upd_off && (sw_req || ovf || udf);
  assign flag_set = ue && !(sw_req && ctrl.quiet_sw);

  ctm_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .cnt(cnt_q), .dir(dir_q), .flag_set(flag_set),
    .ctrl(ctrl), .psc_buf(psc_buf), .arr_buf(arr_buf),
    .sw_req(sw_req), .flag(flag_q)
  );

  ctm_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .run(ctrl.run), .restart(sw_req),
    .load(ue), .psc_new(psc_buf), .tick(tick)
  );

  ctm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .restart(sw_req),
    .load(ue), .arr_new(arr_buf), .cnt(cnt_q), .dir(dir_q),
    .arr_act(arr_act), .ovf(ovf), .udf(udf)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) upd_pulse <= 1'b0;
    else        upd_pulse <= ue;
  end

  assign dir_o = dir_q;
  assign irq   = flag_q && ctrl.irq_en;
endmodule

// File: rtl/ctm_checker.sv
module ctm_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt,
  input logic             dir,
  input logic [CNT_W-1:0] arr_act,
  input logic             run,
  input logic             upd_off,
  input logic             quiet,
  input logic             sw_req,
  input logic             flag,
  input logic             upd_pulse
);
  assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_act != '0) |-> (cnt <= arr_act));

  assert_dir_turns_at_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dir) |-> (cnt == arr_act));

  assert_frozen_when_stopped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !sw_req) |=> $stable(cnt));

  assert_no_pulse_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_off |=> !upd_pulse);

  assert_reload_held_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_off |=> $stable(arr_act));

  assert_quiet_sw_no_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_req && quiet && !upd_off && !flag) |=> !flag);
endmodule

bind ctm_top ctm_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt_q), .dir(dir_q), .arr_act(arr_act),
  .run(ctrl.run), .upd_off(ctrl.upd_off), .quiet(ctrl.quiet_sw),
  .sw_req(sw_req), .flag(flag_q), .upd_pulse(upd_pulse)
);

// File: tb/ctm_top_tb.sv
module ctm_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  // psc, reload, enabled clocks, expected count, expected direction
  localparam int V_PSC [NV] = '{0, 0, 0, 1, 2, 0, 3, 0};
  localparam int V_ARR [NV] = '{4, 4, 4, 3, 5, 1, 2, 6};
  localparam int V_N   [NV] = '{3, 5, 8, 9, 12, 1, 13, 20};
  localparam int V_CNT [NV] = '{3, 3, 0, 2, 4, 1, 1, 4};
  localparam int V_DIR [NV] = '{0, 1, 0, 1, 0, 1, 1, 1};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        dir_o, upd_pulse, irq;
  int nchk = 0;
  int nerr = 0;

  ctm_top u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .dir_o(dir_o), .upd_pulse(upd_pulse), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // called at a negedge; uses exactly one rising edge
  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = a[2:0]; wr_data = d[15:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    rd_addr = a[2:0];
    #1;
    v = int'(rd_data);
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(input int p, input int a);
    wr(0, 0); wr(2, p); wr(3, a); wr(1, 1); wr(4, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int v;
    wait_clk(3);
    rst_n = 1'b1;
    // R1 reset state
    rd(5, v); chk("R1 count", v, 0);
    rd(0, v); chk("R1 ctrl", v, 0);
    rd(4, v); chk("R1 flag", v, 0);
    chk("R1 dir", dir_o, 0);
    chk("R1 pulse", upd_pulse, 0);
    chk("R1 irq", irq, 0);

    // R2 R3 sweep positions from the vector table
    for (int i = 0; i < NV; i++) begin
      setup(V_PSC[i], V_ARR[i]);
      wr(0, 1);
      wait_clk(V_N[i]);
      rd(5, v); chk($sformatf("R2 R3 vec%0d count", i), v, V_CNT[i]);
      chk($sformatf("R2 vec%0d dir", i), dir_o, V_DIR[i]);
    end

    // R4 overflow update takes the new reload at once, R12 pulse
    setup(0, 4);
    wr(3, 7);
    wr(0, 1);
    wait_clk(4);
    rd(5, v); chk("R4 new reload at overflow", v, 7);
    chk("R12 pulse after overflow", upd_pulse, 1);
    rd(4, v); chk("R8 flag on overflow", v, 1);
    wr(4, 1);
    wait_clk(6);
    rd(5, v); chk("R2 underflow count", v, 0);
    chk("R2 underflow dir", dir_o, 0);
    rd(4, v); chk("R8 flag on underflow", v, 1);

    // R6 update disable, R10 direction read-only
    setup(0, 4);
    wr(3, 9);
    wr(0, 3);
    wait_clk(4);
    rd(5, v); chk("R6 old reload kept", v, 4);
    rd(4, v); chk("R6 no flag", v, 0);
    chk("R6 no pulse", upd_pulse, 0);
    wr(0, 3);
    chk("R10 dir unchanged by write", dir_o, 1);
    rd(0, v); chk("R10 ctrl readback", v, 19);
    wait_clk(3);
    rd(5, v); chk("R6 keeps sweeping", v, 0);
    wr(0, 1);
    wait_clk(3);
    rd(5, v); chk("R6 update after re-enable", v, 9);
    rd(4, v); chk("R6 flag after re-enable", v, 1);

    // R7 quiet software update
    wr(4, 1); wr(0, 4); wr(3, 3); wr(1, 1);
    rd(5, v); chk("R5 restart count", v, 0);
    chk("R5 restart dir", dir_o, 0);
    rd(4, v); chk("R7 quiet keeps flag clear", v, 0);
    chk("R12 pulse after sw update", upd_pulse, 1);
    wr(0, 13);
    wait_clk(3);
    rd(5, v); chk("R5 loaded reload", v, 3);
    rd(4, v); chk("R7 hw event sets flag", v, 1);
    chk("R8 irq with enable", irq, 1);

    // R8 write-one-to-clear, R5 non-quiet software update
    wr(0, 8);
    wr(4, 0);
    rd(4, v); chk("R8 write 0 keeps flag", v, 1);
    wr(4, 1);
    rd(4, v); chk("R8 write 1 clears flag", v, 0);
    chk("R8 irq follows flag", irq, 0);
    wr(1, 1);
    rd(4, v); chk("R5 sw update sets flag", v, 1);
    chk("R5 irq after sw update", irq, 1);

    // R9 freeze keeps prescaler phase
    setup(1, 5);
    wr(0, 1);
    wait_clk(6);
    rd(5, v); chk("R9 running count", v, 3);
    wr(0, 0);
    wait_clk(10);
    rd(5, v); chk("R9 frozen count", v, 3);
    wr(0, 1);
    wait_clk(1);
    rd(5, v); chk("R9 resumes mid prescale", v, 4);

    // R11 zero reload holds
    setup(0, 0);
    wr(0, 17);
    wait_clk(5);
    rd(5, v); chk("R11 count held", v, 0);
    chk("R10 dir write ignored", dir_o, 0);
    rd(4, v); chk("R11 no events", v, 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule